// File: doc/BRIEF.md
# Change-of-Flow Trace Capture Buffer

This block keeps a short history of program flow for an on-chip debug unit. Each cycle it looks at the core's 16-bit address, its 8-bit data bus and two change-of-flow flags. A qualifying cycle writes one 16-bit word into an eight-entry store. Flag bit 1 marks an indirect jump or call destination, a return, or a vector fetch, and it stores the current address. Flag bit 0 marks a taken conditional branch, and it stores the branch source, which is the address seen one cycle earlier minus two.

A debugger sets the mode and then arms the unit. In begin-trigger mode nothing is stored until the trigger pulse arrives. After the trigger the unit keeps storing until the store holds eight words, then disarms and can request a CPU breakpoint. In end-trigger mode the unit stores from the moment it is armed. It overwrites its oldest entry when the store is full and stops on the trigger, so it keeps the last eight entries before the stop. Event-only mode stores the data-bus byte on each trigger pulse and always behaves as begin-trigger. Once disarmed, the host pops entries oldest first.

The controller has five states. IDLE is disarmed. WAIT is armed in begin mode, before the trigger. BEGIN is storing after the trigger. END is storing until the trigger. EVENT is event-only storing. The transitions are: IDLE to WAIT, END or EVENT on arm; WAIT to BEGIN on the trigger; BEGIN to IDLE on fill; EVENT to IDLE on fill; END to IDLE on the trigger. Every armed state returns to IDLE when the enable drops.

Top module: `cof_trace_buf`

## Requirements
- R1: The store holds eight 16-bit words, and `cnt` never exceeds 8.
- R2: While storing in BEGIN or END, a cycle with `cof[1]`=1 writes `core_addr`. This bit wins when both flag bits are set.
- R3: While storing in BEGIN or END, a cycle with `cof`=2'b01 writes the `core_addr` of the previous cycle minus 2, modulo 2^16.
- R4: Arming with `mode_event`=0 and `mode_end`=0 enters WAIT. No cycle in WAIT writes anything, including the trigger cycle. The trigger moves the unit to BEGIN. The write that brings `cnt` to 8 returns the unit to IDLE.
- R5: Arming with `mode_event`=0 and `mode_end`=1 enters END, which stores from the next cycle on. In END, a trigger cycle still stores a change-of-flow entry that falls in the same cycle, and then the unit returns to IDLE.
- R6: In END, a write to a full store drops the oldest entry, and `cnt` stays at 8.
- R7: Arming with `mode_event`=1 enters EVENT whatever the value of `mode_end`. Each trigger pulse writes {8'h00, `core_data``}, and change-of-flow flags write nothing. The write that brings `cnt` to 8 returns the unit to IDLE.
- R8: A pop acts only when `en`=1, the unit is in IDLE and `cnt`>0. It removes the oldest entry. `rd_data` shows the oldest entry, or 0 when the store is empty.
- R9: `brk_req` is a one-cycle pulse. It follows the write that fills the store in BEGIN or EVENT while `brk_en`=1. It never pulses in END.
- R10: `arm_set` acts only when `en`=1 and the unit is in IDLE, and then it empties the store. Taking `en` low disarms the unit on the next edge and keeps the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Unit enable |
| arm_set | input | 1 | Arm request, sampled in IDLE |
| mode_end | input | 1 | 1 = end-trigger, 0 = begin-trigger |
| mode_event | input | 1 | 1 = event-only capture |
| brk_en | input | 1 | Allow breakpoint request on fill |
| trig | input | 1 | Single-cycle trigger pulse |
| core_addr | input | 16 | Core address |
| core_data | input | 8 | Core data bus |
| cof | input | 2 | Change-of-flow flags |
| pop | input | 1 | Remove oldest entry |
| armed | output | 1 | Unit is armed |
| cnt | output | 4 | Number of valid entries |
| rd_data | output | 16 | Oldest entry, 0 when empty |
| brk_req | output | 1 | Breakpoint request pulse |

## Verification
The bench fills the store with branches that alternate between the two kinds. A design that took the branch address from the current cycle, or forgot the subtraction, stores the wrong sources. It drives 12 writes before an end trigger that carries its own branch. A design that stalls at full, lets the count grow past 8, or drops the final entry shows the wrong count or the wrong readout order. It also probes the ignored inputs: a trigger cycle in WAIT, flags in event-only mode, pops while armed, and re-arming while armed. A design that leaks any of these shows a count that moves when it should not.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WAIT  = 3'd1,
        S_BEGIN = 3'd2,
        S_END   = 3'd3,
        S_EVENT = 3'd4
    } trace_state_t;
endpackage

// File: rtl/cof_trace_ctrl.sv
module cof_trace_ctrl
    import cof_trace_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             arm_set,
    input  logic             mode_end,
    input  logic             mode_event,
    input  logic             brk_en,
    input  logic             trig,
    input  logic             wr,
    input  logic [CNT_W-1:0] cnt,
    output trace_state_t     state,
    output logic             armed,
    output logic             clr,
    output logic             cap_cof,
    output logic             cap_evt,
    output logic             brk_req
);
    trace_state_t state_nxt;
    logic         fill;
    logic         brk_nxt;

    // The write that makes the store full.
    assign fill = wr && (cnt == CNT_W'(DEPTH - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: begin
                if (en && arm_set) begin
                    if (mode_event)    state_nxt = S_EVENT;
                    else if (mode_end) state_nxt = S_END;
                    else               state_nxt = S_WAIT;
                end
            end
            S_WAIT: begin
                if (!en)       state_nxt = S_IDLE;
                else if (trig) state_nxt = S_BEGIN;
            end
            S_BEGIN: begin
                if (!en || fill) state_nxt = S_IDLE;
            end
            S_END: begin
                if (!en || trig) state_nxt = S_IDLE;
            end
            S_EVENT: begin
                if (!en || fill) state_nxt = S_IDLE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    assign brk_nxt = en && brk_en && fill &&
                     ((state == S_BEGIN) || (state == S_EVENT));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            brk_req <= 1'b0;
        end else begin
            state   <= state_nxt;
            brk_req <= brk_nxt;
        end
    end

    // Outputs
    always_comb begin
        armed   = (state != S_IDLE);
        clr     = (state == S_IDLE) && en && arm_set;
        cap_cof = en && ((state == S_BEGIN) || (state == S_END));
        cap_evt = en && (state == S_EVENT) && trig;
    end

    // R5: an end trigger always stops capture
    p_end_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_END && trig) |=> (state == S_IDLE));

    // R4: the filling write ends a begin-trigger run
    p_fill_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BEGIN && wr && cnt == CNT_W'(DEPTH - 1)) |=> (state == S_IDLE));

    // R9: the breakpoint request lasts one cycle
    p_brk_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);

    // R10: a disabled unit is idle after one edge
    p_dis_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == S_IDLE));
endmodule

// File: rtl/cof_trace_sel.sv
module cof_trace_sel #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_data,
    input  logic [1:0]        cof,
    input  logic              cap_cof,
    input  logic              cap_evt,
    output logic              wr,
    output logic [ADDR_W-1:0] wr_word
);
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_addr <= '0;
        else        prev_addr <= core_addr;
    end

    always_comb begin
        wr = (cap_cof && (cof != 2'b00)) || cap_evt;
        if (cap_evt)     wr_word = {{(ADDR_W-DATA_W){1'b0}}, core_data};
        else if (cof[1]) wr_word = core_addr;
        else             wr_word = prev_addr - ADDR_W'(2);
    end

    // R3: a branch-only cycle writes the previous address minus two
    p_branch_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_cof && cof == 2'b01) |-> (wr_word == $past(core_addr) - ADDR_W'(2)));

    // R2: cof[1] writes the current address
    p_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_cof && cof[1]) |-> (wr && wr_word == core_addr));
endmodule

// File: rtl/cof_trace_store.sv
module cof_trace_store #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [W-1:0]     wr_word,
    input  logic             circ,
    input  logic             pop,
    output logic [W-1:0]     rd_word,
    output logic [CNT_W-1:0] cnt
);
    logic [PTR_W-1:0]          wr_ptr, rd_ptr;
    logic [DEPTH-1:0][W-1:0]   slots;
    logic                      full, wr_ok, pop_ok, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full   = (cnt == CNT_W'(DEPTH));
    assign wr_ok  = wr && (!full || circ);
    assign drop   = wr_ok && full;
    assign pop_ok = pop && (cnt != '0) && !wr_ok;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  ent <= '0;
            else if (wr_ok && wr_ptr == PTR_W'(i))       ent <= wr_word;
        end
        assign slots[i] = ent;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok)           wr_ptr <= bump(wr_ptr);
            if (drop || pop_ok)  rd_ptr <= bump(rd_ptr);
            if (wr_ok && !full)  cnt    <= cnt + CNT_W'(1);
            else if (pop_ok)     cnt    <= cnt - CNT_W'(1);
        end
    end

    assign rd_word = (cnt == '0) ? '0 : slots[rd_ptr];

    // R1: the count never passes the depth
    p_cnt_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R6: a circular write to a full store keeps it full
    p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && circ && !clr) |=> (cnt == CNT_W'(DEPTH)));
endmodule

// File: rtl/cof_trace_buf.sv
module cof_trace_buf
    import cof_trace_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              arm_set,
    input  logic              mode_end,
    input  logic              mode_event,
    input  logic              brk_en,
    input  logic              trig,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_data,
    input  logic [1:0]        cof,
    input  logic              pop,
    output logic              armed,
    output logic [CNT_W-1:0]  cnt,
    output logic [ADDR_W-1:0] rd_data,
    output logic              brk_req
);
    trace_state_t      state;
    logic              clr, cap_cof, cap_evt, wr, pop_ok, circ;
    logic [ADDR_W-1:0] wr_word;

    assign pop_ok = pop && en && !armed;
    assign circ   = (state == S_END);

    cof_trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .arm_set(arm_set),
        .mode_end(mode_end), .mode_event(mode_event), .brk_en(brk_en),
        .trig(trig), .wr(wr), .cnt(cnt), .state(state), .armed(armed),
        .clr(clr), .cap_cof(cap_cof), .cap_evt(cap_evt), .brk_req(brk_req)
    );

    cof_trace_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_data(core_data),
        .cof(cof), .cap_cof(cap_cof), .cap_evt(cap_evt),
        .wr(wr), .wr_word(wr_word)
    );

    cof_trace_store #(.DEPTH(DEPTH), .W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr(wr), .wr_word(wr_word),
        .circ(circ), .pop(pop_ok), .rd_word(rd_data), .cnt(cnt)
    );

    // R8: pops while armed leave the count alone
    p_pop_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pop && !wr && !clr) |=> (cnt == $past(cnt)));

    // R4: nothing is held while waiting for the trigger
    p_wait_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT) |-> (cnt == '0));

    // R7: event entries carry a zero high byte
    p_evt_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> (wr_word[ADDR_W-1:DATA_W] == '0));
endmodule

// File: tb/cof_trace_buf_tb.sv
module cof_trace_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, arm_set = 1'b0, mode_end = 1'b0, mode_event = 1'b0;
    logic        brk_en = 1'b0, trig = 1'b0, pop = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  core_data = '0;
    logic [1:0]  cof = '0;
    logic        armed, brk_req;
    logic [3:0]  cnt;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cof_trace_buf u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .arm_set(arm_set),
        .mode_end(mode_end), .mode_event(mode_event), .brk_en(brk_en),
        .trig(trig), .core_addr(core_addr), .core_data(core_data), .cof(cof),
        .pop(pop), .armed(armed), .cnt(cnt), .rd_data(rd_data), .brk_req(brk_req)
    );

    // Behavioural reference: 0 idle, 1 wait, 2 begin, 3 end, 4 event
    int          m_st = 0;
    logic [15:0] q[$];
    logic [15:0] m_prev = '0;
    logic        m_brk = 1'b0;

    always @(posedge clk) begin
        logic [15:0] v;
        logic        nb;
        nb = 1'b0;
        v  = cof[1] ? core_addr : m_prev - 16'd2;
        if (!rst_n) begin
            m_st = 0; q.delete(); m_prev = '0; m_brk = 1'b0;
        end else begin
            case (m_st)
                0: if (en && arm_set) begin
                       q.delete();
                       m_st = mode_event ? 4 : (mode_end ? 3 : 1);
                   end else if (en && pop && q.size() > 0) void'(q.pop_front());
                1: if (!en) m_st = 0; else if (trig) m_st = 2;
                2: if (!en) m_st = 0;
                   else if (cof != 2'b00) begin
                       q.push_back(v);
                       if (q.size() == 8) begin m_st = 0; nb = brk_en; end
                   end
                3: if (!en) m_st = 0;
                   else begin
                       if (cof != 2'b00) q.push_back(v);
                       if (q.size() > 8) void'(q.pop_front());
                       if (trig) m_st = 0;
                   end
                4: if (!en) m_st = 0;
                   else if (trig) begin
                       q.push_back({8'h00, core_data});
                       if (q.size() == 8) begin m_st = 0; nb = brk_en; end
                   end
                default: m_st = 0;
            endcase
            m_prev = core_addr;
            m_brk  = nb;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(armed == (m_st != 0), "R10 armed", 16'(armed), 16'(m_st != 0));
            chk(cnt == 4'(q.size()), "R6 cnt", 16'(cnt), 16'(q.size()));
            chk(rd_data == (q.size() > 0 ? q[0] : 16'h0), "R8 rd_data", rd_data,
                q.size() > 0 ? q[0] : 16'h0);
            chk(brk_req == m_brk, "R9 brk_req", 16'(brk_req), 16'(m_brk));
        end
    end

    task automatic drive(input logic [1:0] c, input logic t, input logic [15:0] a,
                         input logic [7:0] d, input logic p, input logic ar);
        @(posedge clk); #2;
        cof = c; trig = t; core_addr = a; core_data = d; pop = p; arm_set = ar;
    endtask

    task automatic idle();
        drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0);
    endtask

    task automatic drain(input logic [15:0] exp[], input string tag);
        foreach (exp[k]) begin
            drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0);
            @(negedge clk);
            chk(rd_data == exp[k], tag, rd_data, exp[k]);
        end
        idle();
    endtask

    initial begin
        logic [15:0] e8[];
        e8 = new[8];
        #25;
        chk(armed == 0 && cnt == 0 && rd_data == 0 && brk_req == 0, "R1 reset", {armed, cnt}, 0);
        rst_n = 1'b1;
        idle();
        en = 1'b1; brk_en = 1'b1;

        // Begin-trigger run: R4, R2, R3, R9
        drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        drive(2'b10, 1'b0, 16'h1000, 8'h0, 1'b0, 1'b0);
        drive(2'b11, 1'b1, 16'h1100, 8'h0, 1'b0, 1'b0);
        @(negedge clk);
        chk(cnt == 0 && armed, "R4 nothing stored before trigger", 16'(cnt), 0);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] a;
            a = 16'h4000 + 16'(i * 16);
            if (i % 2 == 0) begin
                drive(i == 4 ? 2'b11 : 2'b10, 1'b0, a, 8'h0, 1'b0, 1'b0);
                e8[i] = a;
            end else begin
                drive(2'b01, 1'b0, a, 8'h0, 1'b0, 1'b0);
                e8[i] = a - 16'd18;
            end
        end
        idle();
        @(negedge clk);
        chk(brk_req == 1, "R9 brk on fill", 16'(brk_req), 1);
        chk(cnt == 8 && !armed, "R4 disarm at eight", 16'(cnt), 8);
        drain(e8, "R3 begin readout");
        @(negedge clk);
        chk(cnt == 0 && rd_data == 0, "R8 empty reads zero", rd_data, 0);

        // End-trigger run with wrap: R5, R6, R8, R10
        mode_end = 1'b1;
        drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        for (int i = 0; i < 11; i++)
            drive(2'b10, 1'b0, 16'h5000 + 16'(i), 8'h0, (i == 3), (i == 5));
        drive(2'b01, 1'b1, 16'h6000, 8'h0, 1'b0, 1'b0);
        idle();
        @(negedge clk);
        chk(cnt == 8 && !armed && brk_req == 0, "R5 end stop", 16'(cnt), 8);
        for (int k = 0; k < 7; k++) e8[k] = 16'h5004 + 16'(k);
        e8[7] = 16'h5008;
        en = 1'b0;
        drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0);
        idle();
        @(negedge clk);
        chk(cnt == 8, "R8 pop ignored when disabled", 16'(cnt), 8);
        en = 1'b1;
        drain(e8, "R6 end readout");

        // Short end run, then disable mid-run: R10
        drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        drive(2'b10, 1'b0, 16'h7000, 8'h0, 1'b0, 1'b0);
        drive(2'b01, 1'b0, 16'h7010, 8'h0, 1'b0, 1'b0);
        idle();
        en = 1'b0;
        idle();
        en = 1'b1;
        @(negedge clk);
        chk(!armed && cnt == 2 && rd_data == 16'h7000, "R10 disable keeps contents", rd_data, 16'h7000);

        // Event-only with end select: R7
        mode_event = 1'b1;
        drive(2'b00, 1'b0, 16'h0, 8'h0, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            drive(2'b10, 1'b0, 16'h8000, 8'h55, 1'b0, 1'b0);
            drive(2'b00, 1'b1, 16'h8100, 8'hA0 + 8'(i), 1'b0, 1'b0);
            e8[i] = 16'h00A0 + 16'(i);
        end
        idle();
        @(negedge clk);
        chk(brk_req == 1 && !armed && cnt == 8, "R7 event fill", 16'(cnt), 8);
        drain(e8, "R7 event readout");
        mode_event = 1'b0; mode_end = 1'b0;

        repeat (3) idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule